// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two two's-complement operands over several clock cycles and returns the full double-width product as a high word and a low word. A client raises `start_i` for one cycle while the unit is idle. The operands and the mode are captured on that edge. One clock later `busy_o` rises. The unit then spends one cycle per multiplier bit and finishes with a single-cycle `done_o` pulse. The product stays on `hi_o`/`lo_o` until the next accepted start.

The datapath has one adder/subtractor and one shift register of twice the operand width. The multiplier is loaded into the low half of that register, and the high half starts at zero. An extra bit sits to the right of the register's least significant bit and starts at zero. Each cycle the register LSB and the extra bit decide the operation: add the multiplicand into the high half, subtract it, or leave the high half alone. The register then shifts right by one place, and the bit that falls out becomes the new extra bit. The high half carries one guard bit, so even the most negative operand cannot overflow an intermediate sum.

An unsigned mode is selected at start. In that mode every set LSB adds the multiplicand, the carry is held in the guard bit, and the shift fills with zero.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `busy_o`=0, `done_o`=0, `hi_o`=0 and `lo_o`=0.
- R2: A `start_i` high at an edge where `busy_o` is 0 is accepted, and `busy_o` is 1 after that edge.
- R3: `done_o` rises exactly WIDTH clock edges after the accepting edge, and `busy_o` falls on that same edge. `done_o` stays high for exactly one cycle.
- R4: With `unsigned_i`=0 at start, {`hi_o`,`lo_o`} equals the signed product of the two operands while `done_o` is high. `hi_o` is the upper WIDTH bits and `lo_o` the lower WIDTH bits.
- R5: In signed mode the most negative operand times itself gives 2^(2·WIDTH−2), and times −1 gives 2^(WIDTH−1), with every bit exact.
- R6: With `unsigned_i`=1 at start, both operands are read as unsigned, and {`hi_o`,`lo_o`} is their unsigned product when `done_o` is high.
- R7: A `start_i` while `busy_o` is 1 is ignored. The running product and its completion cycle are unchanged.
- R8: While `busy_o` is 0 and no start is accepted, `hi_o` and `lo_o` hold their value.
- R9: `unsigned_i` and both operand inputs are sampled only on the accepting edge. Changes to them while busy have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a multiply (taken only when idle) |
| unsigned_i | input | 1 | 1 = unsigned operands, 0 = two's complement |
| multiplicand_i | input | WIDTH | Multiplicand operand |
| multiplier_i | input | WIDTH | Multiplier operand |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | WIDTH | Upper half of the product |
| lo_o | output | WIDTH | Lower half of the product |

## Verification
Once a start is accepted, `busy_o` is due one edge later. `done_o` and the final `hi_o`/`lo_o` are due WIDTH edges after the accepting edge, and `done_o` falls one edge after that. The reference model in the bench advances on the same edges as the design. It records the operands at acceptance, counts WIDTH edges, and only then publishes its product. Every comparison is sampled on the falling clock edge so that registered outputs have settled. The product words are compared only while the model reports idle, because intermediate register contents are not part of the contract.

// File: rtl/booth_pkg.sv
// Shared types for the sequential Booth multiplier.
package booth_pkg;

    // Operation applied to the upper half of the product register in one iteration.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
// Picks the per-iteration operation.
// Signed mode: the register LSB and the extra bit form a pair; 10 subtracts, 01 adds, 00/11 hold.
// Unsigned mode: a set LSB adds and a clear LSB holds.
// Assumes: purely combinational, inputs are registered elsewhere.
module booth_recoder
    import booth_pkg::*;
(
    input  logic      lsb_i,
    input  logic      extra_i,
    input  logic      uns_i,
    output booth_op_e op_o
);

    // Decode the bit pair or the single bit into an operation.
    always_comb begin
        if (uns_i) begin
            op_o = lsb_i ? OP_ADD : OP_HOLD;
        end else begin
            unique case ({lsb_i, extra_i})
                2'b10:   op_o = OP_SUB;
                2'b01:   op_o = OP_ADD;
                default: op_o = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/booth_addsub.sv
// Adds, subtracts or passes the multiplicand against the guarded upper half.
// The upper half is WIDTH+1 bits. The multiplicand is sign- or zero-extended to match,
// so no intermediate sum can overflow.
// Assumes: combinational, one instance per datapath.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   acc_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic             uns_i,
    input  booth_op_e        op_i,
    output logic [WIDTH:0]   sum_o
);

    logic [WIDTH:0] mcand_ext;

    // Extend the multiplicand to the guarded width according to the mode.
    always_comb begin
        mcand_ext = uns_i ? {1'b0, mcand_i} : {mcand_i[WIDTH-1], mcand_i};
    end

    // Apply the selected operation.
    always_comb begin
        unique case (op_i)
            OP_ADD:  sum_o = acc_i + mcand_ext;
            OP_SUB:  sum_o = acc_i - mcand_ext;
            default: sum_o = acc_i;
        endcase
    end

endmodule

// File: rtl/booth_ctrl.sv
// Sequencer: accepts a start when idle, counts WIDTH iterations and pulses done once.
// Assumes: synchronous active-low reset; a start while busy is dropped.
module booth_ctrl #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] iter_q;

    // A start is taken only while idle.
    always_comb begin
        accept_o = start_i & ~busy_o;
    end

    // Iteration counter, busy flag and one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter_q <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                busy_o <= 1'b1;
                iter_q <= '0;
            end else if (busy_o) begin
                if (iter_q == LAST) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    iter_q <= iter_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/booth_seq_mult.sv
// Sequential radix-2 Booth multiplier, one multiplier bit per clock.
// The product register holds {guard+upper, lower}, and the lower half is loaded with the multiplier.
// Each busy cycle: recode, add/sub into the upper half, then shift the whole register right by one.
// The fill bit is the guarded sign in signed mode and zero in unsigned mode.
// Assumes: synchronous active-low reset; operands and mode are captured at the accepting edge.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             unsigned_i,
    input  logic [WIDTH-1:0] multiplicand_i,
    input  logic [WIDTH-1:0] multiplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);

    logic             accept;
    logic [WIDTH:0]   acc_q;
    logic [WIDTH-1:0] low_q;
    logic             extra_q;
    logic [WIDTH-1:0] mcand_q;
    logic             uns_q;
    booth_op_e        op;
    logic [WIDTH:0]   sum;
    logic             fill;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    booth_recoder u_rec (
        .lsb_i   (low_q[0]),
        .extra_i (extra_q),
        .uns_i   (uns_q),
        .op_o    (op)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_alu (
        .acc_i   (acc_q),
        .mcand_i (mcand_q),
        .uns_i   (uns_q),
        .op_i    (op),
        .sum_o   (sum)
    );

    // Bit shifted into the top of the guarded upper half.
    always_comb begin
        fill = uns_q ? 1'b0 : sum[WIDTH];
    end

    // Product register: load on accept, add/sub and shift on each busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            low_q   <= '0;
            extra_q <= 1'b0;
            mcand_q <= '0;
            uns_q   <= 1'b0;
        end else if (accept) begin
            acc_q   <= '0;
            low_q   <= multiplier_i;
            extra_q <= 1'b0;
            mcand_q <= multiplicand_i;
            uns_q   <= unsigned_i;
        end else if (busy_o) begin
            acc_q   <= {fill, sum[WIDTH:1]};
            low_q   <= {sum[0], low_q[WIDTH-1:1]};
            extra_q <= low_q[0];
        end
    end

    // Result words.
    always_comb begin
        hi_o = acc_q[WIDTH-1:0];
        lo_o = low_q;
    end

endmodule

// File: rtl/booth_seq_mult_chk.sv
// Assertion checker for booth_seq_mult, attached by bind.
// It keeps its own operand copies and a busy-cycle counter; it does not look inside the design.
module booth_seq_mult_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             unsigned_i,
    input logic [WIDTH-1:0] multiplicand_i,
    input logic [WIDTH-1:0] multiplier_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);

    logic [WIDTH-1:0]   a_q, b_q;
    logic               u_q;
    int unsigned        busy_cnt;
    logic [2*WIDTH-1:0] exp_prod;

    // Capture the operands at acceptance and count busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            u_q      <= 1'b0;
            busy_cnt <= 0;
        end else if (start_i && !busy_o) begin
            a_q      <= multiplicand_i;
            b_q      <= multiplier_i;
            u_q      <= unsigned_i;
            busy_cnt <= 0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    // Expected product from the captured operands.
    always_comb begin
        if (u_q)
            exp_prod = {{WIDTH{1'b0}}, a_q} * {{WIDTH{1'b0}}, b_q};
        else
            exp_prod = {{WIDTH{a_q[WIDTH-1]}}, a_q} * {{WIDTH{b_q[WIDTH-1]}}, b_q};
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);                                  // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                               // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == WIDTH && !busy_o));                        // R3
    AST_SIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !u_q) |-> ({hi_o, lo_o} == exp_prod));                  // R4
    AST_UNSIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && u_q) |-> ({hi_o, lo_o} == exp_prod));                   // R6
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_cnt < WIDTH - 1) |=> busy_o);                      // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({hi_o, lo_o}));                  // R8

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/booth_seq_mult_tb.sv
// Self-checking bench: behavioural reference model compared on every falling edge, plus directed cases.
module booth_seq_mult_tb;

    localparam int W = 32;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         unsigned_i = 1'b0;
    logic [W-1:0] multiplicand_i = '0;
    logic [W-1:0] multiplier_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    booth_seq_mult #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .unsigned_i(unsigned_i),
        .multiplicand_i(multiplicand_i), .multiplier_i(multiplier_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    logic         m_busy = 0, m_done = 0, m_mode = 0;
    int           m_cnt = 0;
    logic [2*W-1:0] m_res = '0, m_pend = '0;

    function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic uns);
        longint sa, sb;
        if (uns) return {{W{1'b0}}, a} * {{W{1'b0}}, b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        return 64'(sa * sb);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_cnt <= 0; m_res <= '0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                if (m_cnt == W - 1) begin
                    m_busy <= 0; m_done <= 1; m_res <= m_pend;
                end else m_cnt <= m_cnt + 1;
            end else if (start_i) begin
                m_busy <= 1; m_cnt <= 0; m_mode <= unsigned_i;
                m_pend <= ref_mul(multiplicand_i, multiplier_i, unsigned_i);
            end
        end
    end

    task automatic check(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 busy", {63'b0, busy_o}, {63'b0, m_busy});
            check("R3 done", {63'b0, done_o}, {63'b0, m_done});
            if (!m_busy) check(m_mode ? "R6 idle product" : "R4/R8 idle product", {hi_o, lo_o}, m_res);
        end
    end

    task automatic launch(logic [W-1:0] a, logic [W-1:0] b, logic uns);
        @(negedge clk);
        multiplicand_i = a; multiplier_i = b; unsigned_i = uns; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Runs one multiply and checks done and product at the due cycle.
    task automatic run_mult(logic [W-1:0] a, logic [W-1:0] b, logic uns, string tag);
        launch(a, b, uns);
        repeat (W) @(negedge clk);
        check({tag, " done"}, {63'b0, done_o}, 64'd1);
        check(tag, {hi_o, lo_o}, ref_mul(a, b, uns));
    endtask

    initial begin : wd
        wait (cyc >= WATCHDOG);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [2*W-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset busy/done", {62'b0, busy_o, done_o}, 64'd0);
        check("R1 reset product", {hi_o, lo_o}, 64'd0);
        rst_n = 1'b1;

        run_mult(32'd2, 32'd7, 1'b0, "R4 2x7");
        run_mult(32'd2, -32'sd3, 1'b0, "R4 2x-3");
        run_mult(-32'sd12345, -32'sd6789, 1'b0, "R4 neg x neg");
        run_mult(32'h7FFFFFFF, 32'h80000001, 1'b0, "R4 max x -max");
        run_mult(32'h0, 32'hDEADBEEF, 1'b0, "R4 zero");
        run_mult(32'h80000000, 32'h80000000, 1'b0, "R5 min x min");
        check("R5 min x min value", {hi_o, lo_o}, 64'h4000000000000000);
        run_mult(32'h80000000, 32'hFFFFFFFF, 1'b0, "R5 min x -1");
        check("R5 min x -1 value", {hi_o, lo_o}, 64'h0000000080000000);
        run_mult(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R6 max unsigned");
        check("R6 max unsigned value", {hi_o, lo_o}, 64'hFFFFFFFE00000001);
        run_mult(32'h80000000, 32'h00000003, 1'b1, "R6 unsigned high bit");

        // R7: second start while busy is dropped.
        launch(32'd1000, 32'd3000, 1'b0);
        repeat (5) @(negedge clk);
        start_i = 1'b1; multiplicand_i = 32'd5; multiplier_i = 32'd5;
        @(negedge clk);
        start_i = 1'b0;
        repeat (W - 6) @(negedge clk);
        check("R7 done on time", {63'b0, done_o}, 64'd1);
        check("R7 first product kept", {hi_o, lo_o}, 64'd3000000);

        // R9: inputs changed while busy do not matter.
        launch(32'hFFFFFFFE, 32'd3, 1'b0);
        unsigned_i = 1'b1; multiplicand_i = 32'h12345678; multiplier_i = 32'h9ABCDEF0;
        repeat (W) @(negedge clk);
        check("R9 sampled at start", {hi_o, lo_o}, 64'hFFFFFFFFFFFFFFFA);

        // R8: idle outputs hold while inputs move.
        held = {hi_o, lo_o};
        for (int i = 0; i < 6; i++) begin
            multiplicand_i = 32'(i * 77); multiplier_i = 32'(i + 9);
            @(negedge clk);
            check("R8 hold", {hi_o, lo_o}, held);
        end

        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, b;
            a = $urandom; b = $urandom;
            run_mult(a, b, i[0], i[0] ? "R6 sweep" : "R4 sweep");
        end

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule